// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits beside a small microcontroller core and decides which of five interrupt sources the core should service next. Each source raises a one-cycle request strobe. The strobe sets a sticky pending flag, and that flag stays set until the core takes the interrupt. A per-source level bit places each source at either the low or the high execution level. Within a level, a fixed polling order breaks ties. Per-source enable bits and a global enable mask the flags from arbitration without clearing them.

The arbiter keeps a two-entry record of which levels are in service. A new request reaches the core only when its level is strictly above the highest level in service. This lets a low-level handler be preempted once by a high-level one. No handler is ever preempted by a request at its own level or below. The core acknowledges to take the offered source and pulses a return strobe at the end of each handler. After a return, the remaining flags compete again.

Top module: `irq_nest_arbiter`

## Requirements
- R1: A one-cycle pulse on `reqStrobe[i]` sets the pending flag of source i, and the flag stays set on later cycles until that source is acknowledged.
- R2: After reset, no flag is pending, `inService` is 2'b00 and `irqOut` is low.
- R3: If pending enabled sources exist at both levels, `srcIndex` names a source whose `prioLevel` bit is 1 (high level). This holds even when a low-level source comes earlier in polling order.
- R4: Among pending enabled sources at the same level, the lowest index wins. The polling order is index 0 (external 0), 1 (timer 0), 2 (external 1), 3 (timer 1), 4 (serial).
- R5: A source is excluded from arbitration while its `srcEnable` bit is 0 or `globalEnable` is 0. Its flag is kept and competes again once it is unmasked.
- R6: `irqOut` is high only in two cases. Either a pending enabled source exists and nothing is in service, or the best source is high level and only the low level is in service. It is never high while `inService[1]` is set.
- R7: `cpuAck` while `irqOut` is high clears the flag of the source named by `srcIndex`. It also sets the in-service bit of that source's level (`inService[1]` for high, `inService[0]` for low). `cpuAck` while `irqOut` is low has no effect.
- R8: A `retStrobe` clears `inService[1]` if it is set, and otherwise clears `inService[0]`. With nothing in service it has no effect.
- R9: After a return, the flags still pending are arbitrated again. `irqOut` is reasserted with the winner when the rule of R6 allows.
- R10: A `cpuAck` in the same cycle as `retStrobe` is ignored. The return takes effect and no flag is cleared.
- R11: A strobe for a source in the same cycle that source is acknowledged leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqStrobe | input | 5 | One-cycle request pulse per source |
| prioLevel | input | 5 | Execution level per source, 1 = high |
| srcEnable | input | 5 | Individual enable per source |
| globalEnable | input | 1 | Master enable for all sources |
| cpuAck | input | 1 | Core takes the offered interrupt |
| retStrobe | input | 1 | Core finished the current handler |
| irqOut | output | 1 | Interrupt request to the core |
| srcIndex | output | 3 | Index of the winning source |
| inService | output | 2 | Bit 1 high level, bit 0 low level in service |

## Verification
The bench builds the block with its default of five sources and a three-bit index. This is the only configuration for which the polling order and the level register value 5'b10000 have their fixed meaning. Five sources are enough to put two same-level requests and one high-level request in flight together. They also cover both nesting depths, masking while a flag is held, and the same-cycle collisions of acknowledge with return and of acknowledge with a new strobe.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_SRC = 5;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int NUM_LVL = 2;

  typedef struct packed {
    logic ackTake;
    logic retHi;
    logic retLo;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_nest_datapath.sv
module irq_nest_datapath
  import irq_nest_pkg::*;
#(
  parameter int SRC_N = NUM_SRC,
  parameter int IW    = IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] reqStrobe,
  input  logic [SRC_N-1:0] prioLevel,
  input  logic [SRC_N-1:0] srcEnable,
  input  logic             globalEnable,
  input  ctrlStrobes_t     strobes,
  output logic             bestValid,
  output logic             bestLvl,
  output logic [IW-1:0]    bestIdx
);
  logic [SRC_N-1:0] pendFlag;
  logic [SRC_N-1:0] eligible;
  logic [SRC_N-1:0] hiMask;
  logic [SRC_N-1:0] loMask;
  logic [SRC_N-1:0] useMask;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic clearMe;
    assign clearMe = strobes.ackTake && (bestIdx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pendFlag[i] <= 1'b0;
      else if (reqStrobe[i]) pendFlag[i] <= 1'b1;
      else if (clearMe)      pendFlag[i] <= 1'b0;
    end
    assign eligible[i] = pendFlag[i] && srcEnable[i] && globalEnable;
  end

  assign hiMask    = eligible & prioLevel;
  assign loMask    = eligible & ~prioLevel;
  assign bestLvl   = |hiMask;
  assign useMask   = bestLvl ? hiMask : loMask;
  assign bestValid = |eligible;

  always_comb begin
    bestIdx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (useMask[i]) bestIdx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_nest_control.sv
module irq_nest_control
  import irq_nest_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bestValid,
  input  logic               bestLvl,
  input  logic               cpuAck,
  input  logic               retStrobe,
  output logic               irqOut,
  output logic [NUM_LVL-1:0] inService,
  output ctrlStrobes_t       strobes
);
  logic [NUM_LVL-1:0] svcNext;
  logic               mayRequest;

  assign mayRequest = (inService == '0) || (bestLvl && !inService[1]);
  assign irqOut     = bestValid && mayRequest;

  assign strobes.ackTake = cpuAck && irqOut && !retStrobe;
  assign strobes.retHi   = retStrobe && inService[1];
  assign strobes.retLo   = retStrobe && !inService[1] && inService[0];

  always_comb begin
    svcNext = inService;
    if (strobes.retHi) svcNext[1] = 1'b0;
    if (strobes.retLo) svcNext[0] = 1'b0;
    if (strobes.ackTake) svcNext[bestLvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inService <= '0;
    else        inService <= svcNext;
  end
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_nest_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] reqStrobe,
  input  logic [NUM_SRC-1:0] prioLevel,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               globalEnable,
  input  logic               cpuAck,
  input  logic               retStrobe,
  output logic               irqOut,
  output logic [IDX_W-1:0]   srcIndex,
  output logic [NUM_LVL-1:0] inService
);
  ctrlStrobes_t strobes;
  logic         bestValid;
  logic         bestLvl;

  irq_nest_datapath #(.SRC_N(NUM_SRC), .IW(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqStrobe(reqStrobe), .prioLevel(prioLevel),
    .srcEnable(srcEnable), .globalEnable(globalEnable), .strobes(strobes),
    .bestValid(bestValid), .bestLvl(bestLvl), .bestIdx(srcIndex)
  );

  irq_nest_control u_ctl (
    .clk(clk), .rst_n(rst_n), .bestValid(bestValid), .bestLvl(bestLvl),
    .cpuAck(cpuAck), .retStrobe(retStrobe), .irqOut(irqOut),
    .inService(inService), .strobes(strobes)
  );
endmodule

// File: rtl/irq_nest_checker.sv
module irq_nest_checker
  import irq_nest_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] prioLevel,
  input logic               cpuAck,
  input logic               retStrobe,
  input logic               irqOut,
  input logic [IDX_W-1:0]   srcIndex,
  input logic [NUM_LVL-1:0] inService
);
  logic lvlOfIdx;
  assign lvlOfIdx = |(prioLevel & (NUM_SRC'(1) << srcIndex));

  assert_index_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (int'(srcIndex) < NUM_SRC));

  assert_no_irq_when_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inService[1] |-> !irqOut);

  assert_nest_only_upward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && inService[0]) |-> lvlOfIdx);

  assert_ack_marks_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuAck && irqOut && !retStrobe) |=> inService[$past(lvlOfIdx)]);

  assert_ack_idle_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuAck && !irqOut && !retStrobe) |=> (inService == $past(inService)));

  assert_ret_high_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retStrobe && inService[1]) |=> (inService == {1'b0, $past(inService[0])}));

  assert_ret_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retStrobe && inService == 2'b01) |=> (inService == 2'b00));

  assert_ack_with_ret_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (retStrobe && cpuAck && inService == 2'b00) |=> (inService == 2'b00));
endmodule

bind irq_nest_arbiter irq_nest_checker u_chk (
  .clk(clk), .rst_n(rst_n), .prioLevel(prioLevel), .cpuAck(cpuAck),
  .retStrobe(retStrobe), .irqOut(irqOut), .srcIndex(srcIndex), .inService(inService)
);

// File: tb/irq_nest_arbiter_tb.sv
module irq_nest_arbiter_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] reqStrobe = '0;
  logic [4:0] prioLevel = '0;
  logic [4:0] srcEnable = '1;
  logic       globalEnable = 1;
  logic       cpuAck = 0;
  logic       retStrobe = 0;
  logic       irqOut;
  logic [2:0] srcIndex;
  logic [1:0] inService;
  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  irq_nest_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .reqStrobe(reqStrobe), .prioLevel(prioLevel),
    .srcEnable(srcEnable), .globalEnable(globalEnable), .cpuAck(cpuAck),
    .retStrobe(retStrobe), .irqOut(irqOut), .srcIndex(srcIndex), .inService(inService)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic expIrq, logic [2:0] expIdx, logic [1:0] expSvc);
    nRun++;
    if (irqOut !== expIrq || inService !== expSvc || (expIrq && srcIndex !== expIdx)) begin
      nFail++;
      $display("FAIL %s: irq=%0b idx=%0d svc=%b expected irq=%0b idx=%0d svc=%b",
               req, irqOut, srcIndex, inService, expIrq, expIdx, expSvc);
    end
  endtask

  task automatic pulse(logic [4:0] m);
    reqStrobe = m; tick(); reqStrobe = '0;
  endtask

  task automatic ack();
    cpuAck = 1; tick(); cpuAck = 0;
  endtask

  task automatic ret();
    retStrobe = 1; tick(); retStrobe = 0;
  endtask

  task automatic t_reset();
    chk("R2 reset", 0, 0, 2'b00);
  endtask

  task automatic t_same_level();
    prioLevel = '0;
    pulse(5'b01010);
    chk("R4 tie low", 1, 1, 2'b00);
    ack();
    chk("R6 same level blocked", 0, 0, 2'b01);
    pulse(5'b00001);
    chk("R6 earlier order no preempt", 0, 0, 2'b01);
    ret();
    chk("R9 repoll after return", 1, 0, 2'b00);
    ack(); ret();
    chk("R4 remaining source", 1, 3, 2'b00);
    ack(); ret();
    chk("R7 all drained", 0, 0, 2'b00);
  endtask

  task automatic t_level();
    prioLevel = 5'b10000;
    pulse(5'b10001);
    chk("R3 high beats order", 1, 4, 2'b00);
    ack();
    chk("R6 high in service", 0, 0, 2'b10);
    ret();
    chk("R9 low after high", 1, 0, 2'b00);
    ack(); ret();
    chk("R7 drained", 0, 0, 2'b00);
  endtask

  task automatic t_nest();
    prioLevel = 5'b10000;
    pulse(5'b00100);
    ack();
    chk("R7 low marked", 0, 0, 2'b01);
    pulse(5'b10000);
    chk("R6 nest request", 1, 4, 2'b01);
    ack();
    chk("R7 nested both", 0, 0, 2'b11);
    ret();
    chk("R8 high first", 0, 0, 2'b01);
    ret();
    chk("R8 low next", 0, 0, 2'b00);
    ret();
    chk("R8 idle return", 0, 0, 2'b00);
  endtask

  task automatic t_sticky_mask();
    prioLevel = '0;
    srcEnable = 5'b11101;
    pulse(5'b00010);
    repeat (4) tick();
    chk("R5 masked", 0, 0, 2'b00);
    srcEnable = '1; #1;
    chk("R1 R5 held flag visible", 1, 1, 2'b00);
    globalEnable = 0; #1;
    chk("R5 global off", 0, 0, 2'b00);
    cpuAck = 1; tick(); cpuAck = 0;
    chk("R7 ack without irq", 0, 0, 2'b00);
    globalEnable = 1; #1;
    chk("R1 flag kept", 1, 1, 2'b00);
    ack(); ret();
    chk("R7 drained", 0, 0, 2'b00);
  endtask

  task automatic t_collisions();
    prioLevel = '0;
    pulse(5'b00001);
    ack();
    chk("R7 low busy", 0, 0, 2'b01);
    cpuAck = 1; retStrobe = 1; tick(); cpuAck = 0; retStrobe = 0;
    chk("R10 ack with ret ignored", 0, 0, 2'b00);
    pulse(5'b00100);
    chk("R10 setup", 1, 2, 2'b00);
    cpuAck = 1; retStrobe = 1; tick(); cpuAck = 0; retStrobe = 0;
    chk("R10 flag kept", 1, 2, 2'b00);
    cpuAck = 1; reqStrobe = 5'b00100; tick(); cpuAck = 0; reqStrobe = '0;
    chk("R11 ack taken", 0, 0, 2'b01);
    ret();
    chk("R11 flag re-set", 1, 2, 2'b00);
    ack(); ret();
    chk("R11 drained", 0, 0, 2'b00);
  endtask

  initial begin
    repeat (2) tick();
    rst_n = 1; tick();
    t_reset();
    t_same_level();
    t_level();
    t_nest();
    t_sticky_mask();
    t_collisions();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #200000;
    nRun++; nFail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule